// File: doc/BRIEF.md
# Three-Phase Switching Node Error Detector

This block watches the three legs of a half-bridge motor stage. For each leg it records the high-side and low-side on commands that reach the gate drivers. It also takes a digitized comparator bit that tells whether the switching node sits high or low. Once a settling window has passed after a command edge, the node level should agree with the switch that is on. If it does not, the block flags an error for that leg.

The settling window starts on every change of either command of a leg. It lasts for the larger of two programmable counts: the deadtime and the blanking interval. The node is compared only when exactly one switch of the leg is on. The comparator bits are asynchronous to the clock and are resynchronized before use. The per-leg error flags are ORed into one fault line, which a status latch elsewhere in the chip captures.

Top module: `phase_err_det`

## Requirements
- R1: While rst_n is low, every bit of phase_err and fault reads 0.
- R2: With only the high-side command of a leg on (hs_on=1, ls_on=0) and the synchronized node low, that leg's phase_err bit is 1 once the window has elapsed.
- R3: With only the low-side command of a leg on (hs_on=0, ls_on=1) and the synchronized node high, that leg's phase_err bit is 1 once the window has elapsed.
- R4: With both commands of a leg on, that leg never flags, whatever the node level.
- R5: With both commands of a leg off, that leg never flags, and its window counter is held at its start.
- R6: The window is max(dead_cyc, blank_cyc) cycles. Take a command change held steady, with the node wrong. Count the rising edge that first samples the change as edge 1. Then phase_err is 0 after edges 1 through W+1 and 1 after edge W+2.
- R7: Any change of either command of a leg restarts that leg's window, so a new R6 count begins at that change.
- R8: A node input change is compared after two synchronizer stages. A change first sampled at edge A shows on phase_err after edge A+2 and not earlier.
- R9: fault equals the OR of all phase_err bits in every cycle.
- R10: The window counter saturates. A wrong node held for much longer than 2^CW cycles keeps phase_err at 1 without gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_on | input | NPH | High-side on command per leg |
| ls_on | input | NPH | Low-side on command per leg |
| node_in | input | NPH | Asynchronous comparator bit per leg, 1 = node high |
| dead_cyc | input | CW | Deadtime in clock cycles |
| blank_cyc | input | CW | Blanking interval in clock cycles |
| phase_err | output | NPH | Registered per-leg error flag |
| fault | output | 1 | OR of all leg errors |

## Verification
A command change first sampled at edge 1 can raise a flag no earlier than edge W+2, where W is the larger of the two counts. A node change first sampled at edge A reaches the flag after edge A+2. The fault line follows the flags in the same cycle. The bench drives inputs and samples outputs on falling edges. A reference model in the bench advances on every rising edge, and every cycle is compared against it. The directed cases count edges from the change and sample the flag one edge before and one edge after its due cycle.

// File: rtl/phase_err_det.sv
module phase_err_det #(
  parameter int NPH = 3,
  parameter int CW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPH-1:0] hs_on,
  input  logic [NPH-1:0] ls_on,
  input  logic [NPH-1:0] node_in,
  input  logic [CW-1:0]  dead_cyc,
  input  logic [CW-1:0]  blank_cyc,
  output logic [NPH-1:0] phase_err,
  output logic           fault
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [NPH-1:0] sync1, sync2, hs_q, ls_q, err_d;
  logic [CW-1:0]  win;

  assign win = (dead_cyc > blank_cyc) ? dead_cyc : blank_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1     <= '0;
      sync2     <= '0;
      hs_q      <= '0;
      ls_q      <= '0;
      phase_err <= '0;
    end else begin
      sync1     <= node_in;
      sync2     <= sync1;
      hs_q      <= hs_on;
      ls_q      <= ls_on;
      phase_err <= err_d;
    end
  end

  for (genvar p = 0; p < NPH; p++) begin : g_leg
    logic [CW-1:0] cnt;
    logic          restart;

    assign restart = (hs_on[p] != hs_q[p]) || (ls_on[p] != ls_q[p]) ||
                     !(hs_on[p] || ls_on[p]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (restart)      cnt <= '0;
      else if (cnt != CMAX)  cnt <= cnt + 1'b1;
    end

    assign err_d[p] = (cnt >= win) && (hs_q[p] ^ ls_q[p]) && (sync2[p] ^ hs_q[p]);
  end

  assign fault = |phase_err;
endmodule

// File: rtl/phase_err_det_chk.sv
module phase_err_det_chk #(
  parameter int NPH = 3,
  parameter int CW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NPH-1:0] hs_on,
  input logic [NPH-1:0] ls_on,
  input logic [NPH-1:0] phase_err,
  input logic           fault
);
  assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |=> (phase_err == '0));

  assert_fault_or_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault == (|phase_err));

  for (genvar p = 0; p < NPH; p++) begin : g_chk
    assert_both_on_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hs_on[p] && ls_on[p], 2) |-> !phase_err[p]);

    assert_both_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!hs_on[p] && !ls_on[p], 2) |-> !phase_err[p]);

    assert_rise_needs_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phase_err[p]) |-> $past(hs_on[p] ^ ls_on[p], 2));
  end
endmodule

bind phase_err_det phase_err_det_chk #(.NPH(NPH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .hs_on(hs_on), .ls_on(ls_on),
  .phase_err(phase_err), .fault(fault)
);

// File: tb/phase_err_det_tb_top.sv
module phase_err_det_tb_top;
  localparam int NPH = 3;
  localparam int CW  = 8;

  logic clk = 0, rst_n = 0;
  logic [NPH-1:0] hs_on = '0, ls_on = '0, node_in = '0;
  logic [CW-1:0]  dead_cyc = 8'd2, blank_cyc = 8'd1;
  logic [NPH-1:0] phase_err;
  logic           fault;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  phase_err_det #(.NPH(NPH), .CW(CW)) dut_i (.*);

  logic [NPH-1:0] m_s1, m_s2, m_hs, m_ls, m_err;
  int m_since [NPH];

  function automatic int win_f(input int d, input int b);
    return (d > b) ? d : b;
  endfunction

  function automatic logic bad_f(input logic h, input logic l, input logic n, input int since, input int w);
    return (since >= w) && (h ^ l) && (n ^ h);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_hs <= '0; m_ls <= '0; m_err <= '0;
      for (int p = 0; p < NPH; p++) m_since[p] <= 0;
    end else begin
      for (int p = 0; p < NPH; p++) begin
        m_err[p] <= bad_f(m_hs[p], m_ls[p], m_s2[p], m_since[p], win_f(dead_cyc, blank_cyc));
        if (hs_on[p] != m_hs[p] || ls_on[p] != m_ls[p] || !(hs_on[p] || ls_on[p])) m_since[p] <= 0;
        else if (m_since[p] < 255) m_since[p] <= m_since[p] + 1;
      end
      m_s1 <= node_in; m_s2 <= m_s1; m_hs <= hs_on; m_ls <= ls_on;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("R2/R3/R4/R5/R7 model", {29'd0, phase_err}, {29'd0, m_err});
    chk("R9 fault", {31'd0, fault}, {31'd0, |m_err});
  endtask

  task automatic settle();
    hs_on = '0; ls_on = '0; node_in = '0;
    repeat (4) tick();
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset err", {29'd0, phase_err}, 32'd0);
    chk("R1 reset fault", {31'd0, fault}, 32'd0);
    rst_n = 1;
    tick();

    dead_cyc = 8'd5; blank_cyc = 8'd3;
    hs_on[0] = 1'b1;
    repeat (6) tick();
    chk("R6 before window", {31'd0, phase_err[0]}, 32'd0);
    tick();
    chk("R6/R2 at window", {31'd0, phase_err[0]}, 32'd1);
    settle();

    dead_cyc = 8'd2; blank_cyc = 8'd7;
    ls_on[1] = 1'b1; node_in[1] = 1'b1;
    repeat (8) tick();
    chk("R6 blank dominates", {31'd0, phase_err[1]}, 32'd0);
    tick();
    chk("R3 low-side error", {31'd0, phase_err[1]}, 32'd1);
    settle();

    hs_on[2] = 1'b1; ls_on[2] = 1'b1;
    repeat (20) tick();
    chk("R4 both on", {31'd0, phase_err[2]}, 32'd0);
    ls_on[2] = 1'b0; hs_on[2] = 1'b0;
    repeat (20) tick();
    chk("R5 both off", {31'd0, phase_err[2]}, 32'd0);

    dead_cyc = 8'd4; blank_cyc = 8'd0;
    hs_on[0] = 1'b1;
    repeat (3) tick();
    hs_on[0] = 1'b0; ls_on[0] = 1'b1;
    tick();
    ls_on[0] = 1'b0; hs_on[0] = 1'b1;
    repeat (5) tick();
    chk("R7 restart", {31'd0, phase_err[0]}, 32'd0);
    tick();
    chk("R7 restarted window", {31'd0, phase_err[0]}, 32'd1);

    node_in[0] = 1'b1;
    repeat (2) tick();
    chk("R8 sync latency", {31'd0, phase_err[0]}, 32'd1);
    tick();
    chk("R8 node seen", {31'd0, phase_err[0]}, 32'd0);

    node_in[0] = 1'b0;
    repeat (300) tick();
    chk("R10 saturate", {31'd0, phase_err[0]}, 32'd1);
    chk("R9 fault held", {31'd0, fault}, 32'd1);
    settle();

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 99) == 0) begin
        dead_cyc = CW'($urandom_range(0, 12));
        blank_cyc = CW'($urandom_range(0, 12));
      end
      for (int p = 0; p < NPH; p++) begin
        if ($urandom_range(0, 15) == 0) begin
          hs_on[p] = 1'($urandom); ls_on[p] = 1'($urandom);
        end
        if ($urandom_range(0, 9) == 0) node_in[p] = ~node_in[p];
      end
      tick();
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule